// File: doc/BRIEF.md
# Configurable Interleaved Bidirectional Shift Array

This block is a 96-stage serial shift array used to load one display line into a column driver. A run-time mode input splits the stages into either three interleaved chains of 32 stages each, fed three bits per clock, or six interleaved chains of 16 stages each, fed six bits per clock. Chain c (counted from zero) holds the stages c, c+k, c+2k and so on, where k is the chain count. Each shift therefore moves the whole array k positions. All stage values come out in parallel for a downstream latch.

A direction input decides which of two side buses feeds the array and which one carries the cascade output to the next device. Each side bus has separate in, out and output-enable vectors, so a pad ring can turn it into a bidirectional pin group. The bus on the output side is driven combinationally from the last stage of each chain. Shifting, and a synchronous active-low clear, both take place on the falling edge of the clock.

Top module: `ilv_shift_array`

## Requirements
- R1: While `rstN` is 0 at a falling clock edge, all 96 bits of `stages` become 0 at that edge.
- R2: `stages` changes only at falling clock edges. It holds its value across rising edges.
- R3: With `modeThree`=1 and `dirRight`=1, a falling edge loads `aIn[2:0]` into `stages[2:0]` and moves every `stages[i]` to `stages[i+3]`.
- R4: With `modeThree`=0 and `dirRight`=1, a falling edge loads `aIn[5:0]` into `stages[5:0]` and moves every `stages[i]` to `stages[i+6]`.
- R5: With `modeThree`=1 and `dirRight`=0, a falling edge loads `bIn[2:0]` into `stages[95:93]` and moves every `stages[i]` to `stages[i-3]`.
- R6: With `modeThree`=0 and `dirRight`=0, a falling edge loads `bIn[5:0]` into `stages[95:90]` and moves every `stages[i]` to `stages[i-6]`.
- R7: With `dirRight`=1, `bOut[n]` equals `stages[96-k+n]` for n<k (k=3 when `modeThree`=1, otherwise 6), `bOe` is 1 on those lanes, and `aOut` and `aOe` are all 0.
- R8: With `dirRight`=0, `aOut[n]` equals `stages[n]` for n<k, `aOe` is 1 on those lanes, and `bOut` and `bOe` are all 0.
- R9: With `modeThree`=1, bits 5..3 of `aOut`, `aOe`, `bOut` and `bOe` are 0, and bits 5..3 of `aIn` and `bIn` have no effect on `stages`.
- R10: A change of `modeThree` or `dirRight` alters the shift at the first falling edge after the change. The contents already in the stages are kept as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; the array acts on its falling edge |
| rstN | input | 1 | Synchronous active-low clear, sampled on the falling edge |
| modeThree | input | 1 | 1: three chains of 32; 0: six chains of 16 |
| dirRight | input | 1 | 1: feed from bus A toward higher stages; 0: feed from bus B toward lower stages |
| aIn | input | 6 | Side A receive data |
| aOut | output | 6 | Side A cascade data |
| aOe | output | 6 | Side A drive enable per lane |
| bIn | input | 6 | Side B receive data |
| bOut | output | 6 | Side B cascade data |
| bOe | output | 6 | Side B drive enable per lane |
| stages | output | 96 | Parallel stage values; bit i is stage i+1 |

## Verification
The bench switches mode and direction in the middle of a stream. A design that latched the mode at the wrong edge, or that dropped the stored contents on a switch, would then disagree with the per-chain reference at once. A single marked bit is pushed through a full 32-stage chain to check that the cascade lane delivers it after exactly 32 shifts; an off-by-one chain length would deliver it one shift early or late. In three-chain mode the bench holds the unused lanes 4 to 6 high. This exposes a design that takes data from them or drives them. It also samples just after rising edges to catch a design that shifts on the wrong edge.

// File: rtl/isa_pkg.sv
package isa_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // synchronous clear at the next falling edge
    logic shiftUp;  // 1: bus A feeds low stages, data moves upward
    logic three;    // 1: narrow layout with three chains
  } isa_ctrl_t;
endpackage

// File: rtl/isa_ctrl.sv
module isa_ctrl
  import isa_pkg::*;
(
  input  logic      rstN,
  input  logic      modeThree,
  input  logic      dirRight,
  output isa_ctrl_t ctrl
);
  always_comb begin
    ctrl         = '0;
    ctrl.clear   = !rstN;
    ctrl.shiftUp = dirRight;
    ctrl.three   = modeThree;
  end
endmodule

// File: rtl/isa_stage_array.sv
module isa_stage_array
  import isa_pkg::*;
#(
  parameter int STAGES = 96,
  parameter int NARROW = 3,
  parameter int WIDE   = 6
) (
  input  logic              clk,
  input  isa_ctrl_t         ctrl,
  input  logic [WIDE-1:0]   aIn,
  input  logic [WIDE-1:0]   bIn,
  output logic [STAGES-1:0] stg
);
  localparam int TOP_NARROW = STAGES - NARROW;
  localparam int TOP_WIDE   = STAGES - WIDE;

  logic [STAGES-1:0] nxt;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic upNarrow, upWide, dnNarrow, dnWide;

    if (i < NARROW) begin : g_un_in
      assign upNarrow = aIn[i];
    end else begin : g_un_mv
      assign upNarrow = stg[i-NARROW];
    end

    if (i < WIDE) begin : g_uw_in
      assign upWide = aIn[i];
    end else begin : g_uw_mv
      assign upWide = stg[i-WIDE];
    end

    if (i >= TOP_NARROW) begin : g_dn_in
      assign dnNarrow = bIn[i-TOP_NARROW];
    end else begin : g_dn_mv
      assign dnNarrow = stg[i+NARROW];
    end

    if (i >= TOP_WIDE) begin : g_dw_in
      assign dnWide = bIn[i-TOP_WIDE];
    end else begin : g_dw_mv
      assign dnWide = stg[i+WIDE];
    end

    always_comb begin
      unique case ({ctrl.shiftUp, ctrl.three})
        2'b11:   nxt[i] = upNarrow;
        2'b10:   nxt[i] = upWide;
        2'b01:   nxt[i] = dnNarrow;
        default: nxt[i] = dnWide;
      endcase
    end
  end

  always_ff @(negedge clk) begin
    if (ctrl.clear) stg <= '0;
    else            stg <= nxt;
  end
endmodule

// File: rtl/isa_edge_mux.sv
module isa_edge_mux #(
  parameter int STAGES = 96,
  parameter int NARROW = 3,
  parameter int WIDE   = 6
) (
  input  logic              shiftUp,
  input  logic              three,
  input  logic [STAGES-1:0] stg,
  output logic [WIDE-1:0]   aOut,
  output logic [WIDE-1:0]   aOe,
  output logic [WIDE-1:0]   bOut,
  output logic [WIDE-1:0]   bOe
);
  for (genvar n = 0; n < WIDE; n++) begin : g_lane
    localparam bit IN_NARROW = (n < NARROW);
    logic laneOn, tailNarrow, tailWide;

    if (IN_NARROW) begin : g_tn
      assign tailNarrow = stg[STAGES-NARROW+n];
    end else begin : g_tz
      assign tailNarrow = 1'b0;
    end
    assign tailWide = stg[STAGES-WIDE+n];
    assign laneOn   = three ? IN_NARROW : 1'b1;

    always_comb begin
      bOe[n]  = shiftUp & laneOn;
      aOe[n]  = !shiftUp & laneOn;
      bOut[n] = bOe[n] & (three ? tailNarrow : tailWide);
      aOut[n] = aOe[n] & stg[n];
    end
  end
endmodule

// File: rtl/ilv_shift_array.sv
module ilv_shift_array
  import isa_pkg::*;
#(
  parameter int STAGES = 96,
  parameter int NARROW = 3,
  parameter int WIDE   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeThree,
  input  logic              dirRight,
  input  logic [WIDE-1:0]   aIn,
  output logic [WIDE-1:0]   aOut,
  output logic [WIDE-1:0]   aOe,
  input  logic [WIDE-1:0]   bIn,
  output logic [WIDE-1:0]   bOut,
  output logic [WIDE-1:0]   bOe,
  output logic [STAGES-1:0] stages
);
  isa_ctrl_t ctrl;

  isa_ctrl u_ctrl (
    .rstN      (rstN),
    .modeThree (modeThree),
    .dirRight  (dirRight),
    .ctrl      (ctrl)
  );

  isa_stage_array #(.STAGES(STAGES), .NARROW(NARROW), .WIDE(WIDE)) u_arr (
    .clk  (clk),
    .ctrl (ctrl),
    .aIn  (aIn),
    .bIn  (bIn),
    .stg  (stages)
  );

  isa_edge_mux #(.STAGES(STAGES), .NARROW(NARROW), .WIDE(WIDE)) u_mux (
    .shiftUp (ctrl.shiftUp),
    .three   (ctrl.three),
    .stg     (stages),
    .aOut    (aOut),
    .aOe     (aOe),
    .bOut    (bOut),
    .bOe     (bOe)
  );
endmodule

// File: rtl/ilv_shift_array_chk.sv
module ilv_shift_array_chk (
  input logic        clk,
  input logic        rstN,
  input logic        modeThree,
  input logic        dirRight,
  input logic [5:0]  aIn,
  input logic [5:0]  aOut,
  input logic [5:0]  aOe,
  input logic [5:0]  bIn,
  input logic [5:0]  bOut,
  input logic [5:0]  bOe,
  input logic [95:0] stages
);
  logic clearSeen = 1'b0;
  always_ff @(negedge clk) clearSeen <= !rstN;

  always @(posedge clk) begin
    if (clearSeen) begin
      p_clear_r1: assert (stages == '0);
    end
  end

  p_up_narrow_r3: assert property (@(negedge clk) disable iff (!rstN)
    (modeThree && dirRight) |=>
      (stages[2:0] == $past(aIn[2:0]) && stages[95:3] == $past(stages[92:0])));

  p_up_wide_r4: assert property (@(negedge clk) disable iff (!rstN)
    (!modeThree && dirRight) |=>
      (stages[5:0] == $past(aIn) && stages[95:6] == $past(stages[89:0])));

  p_dn_narrow_r5: assert property (@(negedge clk) disable iff (!rstN)
    (modeThree && !dirRight) |=>
      (stages[95:93] == $past(bIn[2:0]) && stages[92:0] == $past(stages[95:3])));

  p_dn_wide_r6: assert property (@(negedge clk) disable iff (!rstN)
    (!modeThree && !dirRight) |=>
      (stages[95:90] == $past(bIn) && stages[89:0] == $past(stages[95:6])));

  p_out_b_r7: assert property (@(posedge clk) disable iff (!rstN)
    dirRight |-> (aOe == '0 && aOut == '0 &&
      (modeThree ? (bOe == 6'b000111 && bOut[2:0] == stages[95:93])
                 : (bOe == 6'b111111 && bOut == stages[95:90]))));

  p_out_a_r8: assert property (@(posedge clk) disable iff (!rstN)
    !dirRight |-> (bOe == '0 && bOut == '0 &&
      (modeThree ? (aOe == 6'b000111 && aOut[2:0] == stages[2:0])
                 : (aOe == 6'b111111 && aOut == stages[5:0]))));

  p_idle_lanes_r9: assert property (@(posedge clk) disable iff (!rstN)
    modeThree |-> (aOut[5:3] == '0 && aOe[5:3] == '0 &&
                   bOut[5:3] == '0 && bOe[5:3] == '0));
endmodule

bind ilv_shift_array ilv_shift_array_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeThree (modeThree),
  .dirRight  (dirRight),
  .aIn       (aIn),
  .aOut      (aOut),
  .aOe       (aOe),
  .bIn       (bIn),
  .bOut      (bOut),
  .bOe       (bOe),
  .stages    (stages)
);

// File: tb/ilv_shift_array_tb_top.sv
`timescale 1ns/1ps
module ilv_shift_array_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeThree = 1'b1;
  logic        dirRight = 1'b1;
  logic [5:0]  aIn = '0, bIn = '0;
  logic [5:0]  aOut, aOe, bOut, bOe;
  logic [95:0] stages;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [95:0] model = '0;

  always #2.5 clk = ~clk;

  ilv_shift_array dut_i (
    .clk(clk), .rstN(rstN), .modeThree(modeThree), .dirRight(dirRight),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe), .stages(stages)
  );

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-chain reference: chain c holds positions c, c+k, ...; head is position c
  function automatic logic [95:0] refNext(input logic [95:0] old, input logic three,
                                          input logic right, input logic [5:0] a,
                                          input logic [5:0] b);
    int k = three ? 3 : 6;
    int len = 96 / k;
    logic [95:0] r = old;
    for (int c = 0; c < k; c++) begin
      if (right) begin
        for (int j = len - 1; j > 0; j--) r[c + j*k] = old[c + (j-1)*k];
        r[c] = a[c];
      end else begin
        for (int j = 0; j < len - 1; j++) r[c + j*k] = old[c + (j+1)*k];
        r[c + (len-1)*k] = b[c];
      end
    end
    return r;
  endfunction

  task automatic chkEdges(input string tag);
    int k = modeThree ? 3 : 6;
    logic [5:0] expA = '0, expAe = '0, expB = '0, expBe = '0;
    for (int c = 0; c < k; c++) begin
      if (dirRight) begin
        expB[c] = model[96 - k + c];
        expBe[c] = 1'b1;
      end else begin
        expA[c] = model[c];
        expAe[c] = 1'b1;
      end
    end
    chk({tag, " aOut"}, {90'b0, aOut}, {90'b0, expA});
    chk({tag, " aOe"},  {90'b0, aOe},  {90'b0, expAe});
    chk({tag, " bOut"}, {90'b0, bOut}, {90'b0, expB});
    chk({tag, " bOe"},  {90'b0, bOe},  {90'b0, expBe});
  endtask

  // one falling edge with current inputs, then checks
  task automatic step(input string tag);
    logic [95:0] held;
    if (!rstN) model = '0;
    else model = refNext(model, modeThree, dirRight, aIn, bIn);
    @(negedge clk); #1;
    chk({tag, " stages"}, stages, model);
    chkEdges(tag);
    held = stages;
    @(posedge clk); #0.5;
    chk("R2 hold across rising edge", stages, held);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    aIn = 6'h3f; bIn = 6'h3f;
    repeat (3) step("R1 reset clear");
    chk("R1 reset all zero", stages, '0);
    rstN = 1'b1;

    // R9: unused lanes high in narrow mode must not enter
    modeThree = 1'b1; dirRight = 1'b1; aIn = 6'b111000;
    step("R9 idle input lanes");
    chk("R9 stages still zero", stages, '0);

    // R3: one marked bit through a full 32-stage chain
    aIn = 6'b000101; step("R3 marker in");
    aIn = 6'b000000;
    repeat (30) step("R3 travel");
    chk("R3 marker not yet out", {90'b0, bOut}, '0);
    step("R3 travel last");
    chk("R3 marker at cascade", {90'b0, bOut}, {90'b0, 6'b000101});

    // R5: narrow left fill
    dirRight = 1'b0;
    for (int i = 0; i < 20; i++) begin bIn = 6'($urandom); step("R5 narrow left"); end
    // R6 / R4 / R10: wide modes, switching mid-stream
    modeThree = 1'b0;
    for (int i = 0; i < 20; i++) begin bIn = 6'($urandom); step("R6 wide left"); end
    dirRight = 1'b1;
    for (int i = 0; i < 20; i++) begin aIn = 6'($urandom); step("R4 wide right"); end
    modeThree = 1'b1; dirRight = 1'b0;
    step("R10 switch to narrow left");

    // random mix: R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(7) == 0) modeThree = 1'($urandom);
      if ($urandom_range(5) == 0) dirRight = 1'($urandom);
      aIn = 6'($urandom); bIn = 6'($urandom);
      step("R7 R8 random");
    end

    // R1 mid-stream clear
    rstN = 1'b0; step("R1 mid clear");
    chk("R1 mid clear zero", stages, '0);
    rstN = 1'b1;
    step("R1 after clear");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule